// File: doc/BRIEF.md
# NAND Flash Bus Timing Controller

This block drives an 8-bit NAND flash bus from a word-addressed register interface. Each host write to the command, address or data register, and each host read of the data register, becomes exactly one bus cycle. The strobe in that cycle, write-enable or read-enable, is shaped by programmable setup, pulse, hold and ready-wait counts, all counted in host clocks. Reads use one set of counts and writes use another. The block also owns chip enable, which software can force low for the whole length of a multi-cycle flash command. It samples the flash ready/busy pin through a synchronizer and keeps two interrupt flags. One flag marks a rising edge of ready. The other marks the moment a programmed transfer count runs out.

The host side uses a valid/ready request channel. A request is taken on a clock edge where `host_req_valid` and `host_req_ready` are both high. Ready is low for as long as a bus cycle is in flight, so the host must hold its request stable until it is accepted. Register reads answer with a single-cycle `host_rsp_valid` pulse, and the host must take that pulse when it comes. A read of a non-data register answers in the cycle after acceptance. A data read answers in the first cycle after its bus cycle has finished, which is also the first cycle in which ready is high again.

Register map (word index on `host_req_addr`): 0 command (write), 1 address (write), 2 data (read/write), 3 configuration, 4 status (read), 5 control (write), 6 raw interrupt flags (read), 7 interrupt enable, 8 interrupt clear (write 1 to clear), 9 timing, 10 transfer count. Writes to read-only registers are ignored, and reads of write-only registers return 0.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset: ce_n, we_n and re_n are high; cle, ale and irq are low; host_req_ready is high. The timing register reads back the parameter TIM_RST, and the configuration, raw-interrupt, interrupt-enable and transfer-count registers all read 0.
- R2: A command write drives bits [7:0] of the written word on nand_dq_out while we_n is low, with cle high and ale low.
- R3: An address write drives bits [7:0] of the written word while we_n is low, with ale high and cle low.
- R4: A bus cycle has three phases in this order: setup, pulse and hold. Setup lasts S clocks, with CE low and the strobe high. The pulse lasts max(W,1) clocks, with the strobe low. Hold lasts H clocks, with CE low and the strobe high. A value of 0 in S or H skips that phase. Writes take their counts from timing bits [27:24]=W, [23:20]=H and [19:16]=S. Reads take them from bits [11:8]=W, [7:4]=H and [3:0]=S.
- R5: After hold, CE returns high and host_req_ready stays low for a further Y clocks. Y comes from timing bits [31:28] for writes and [15:12] for reads, and a value of 0 means no wait.
- R6: A data read returns, in host_rsp_data[7:0], the value nand_dq_in had in the last clock of the read pulse. Bits [31:8] of that response are zero. A data write drives its byte while we_n is low.
- R7: While configuration bit [5] is set, ce_n stays low even between bus cycles. While it is clear, ce_n is low only during setup, pulse and hold.
- R8: Status bit [0] reads the synchronized nand_rdy level, and status bit [2] reads 0.
- R9: Raw interrupt bit [0] is set by a rising edge of the synchronized ready pin, and bit [1] is set by transfer-complete. Writing 1s to the interrupt-clear register clears the matching bits. irq is the OR of the raw bits that are enabled by the matching interrupt-enable bits [1:0].
- R10: The transfer count goes down by one at the end of each data bus cycle, but only while it is non-zero. Command and address cycles leave it unchanged. The step that takes it from 1 to 0 sets raw interrupt bit [1].
- R11: Writing control bit [2] returns configuration, interrupt enable, raw interrupts, timing and transfer count to their reset values.
- R12: host_req_ready is low in every clock from the acceptance of a bus-cycle request until the ready-wait has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Request valid |
| host_req_ready | output | 1 | Request accepted when high together with valid |
| host_req_write | input | 1 | 1 = register write, 0 = register read |
| host_req_addr | input | 4 | Register word index |
| host_req_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | One-cycle read response strobe |
| host_rsp_data | output | 32 | Read response data |
| irq | output | 1 | Enabled interrupt request |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven toward flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte from flash |
| nand_rdy | input | 1 | Flash ready/busy pin, high = ready |

## Verification
The hardest point to reach from the ports is the exact clock in which read data is captured. A flash model that simply holds a steady byte cannot tell the last pulse clock apart from any other clock. The bench therefore drives a new byte onto nand_dq_in in every clock of the read pulse, so a capture that is one clock early or late returns a different value. The bench also measures the length of each phase at the pins, and it walks the transfer count down through 1 to 0 and then one more step, so that the single clock in which the flag is set can be seen.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_RWAIT} phase_e;
  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WDAT, OP_RDAT} op_e;

  // field order matches one 16-bit half of the timing register, MSB first
  typedef struct packed {
    logic [3:0] rwait;
    logic [3:0] width;
    logic [3:0] hold;
    logic [3:0] setup;
  } strobe_tim_t;

  localparam logic [3:0] RA_CMD    = 4'd0;
  localparam logic [3:0] RA_ADDR   = 4'd1;
  localparam logic [3:0] RA_DATA   = 4'd2;
  localparam logic [3:0] RA_CFG    = 4'd3;
  localparam logic [3:0] RA_STAT   = 4'd4;
  localparam logic [3:0] RA_CTRL   = 4'd5;
  localparam logic [3:0] RA_IRAW   = 4'd6;
  localparam logic [3:0] RA_IEN    = 4'd7;
  localparam logic [3:0] RA_ICLR   = 4'd8;
  localparam logic [3:0] RA_TIMING = 4'd9;
  localparam logic [3:0] RA_COUNT  = 4'd10;

  function automatic logic [3:0] pulse_load(input logic [3:0] w);
    return (w == 4'd0) ? 4'd0 : w - 4'd1;
  endfunction
endpackage

// File: rtl/nfc_rdy_sync.sv
module nfc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      prev  <= 1'b1;
    end else begin
      shreg <= {shreg[STAGES-2:0], pin};
      prev  <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign rise  = level & ~prev;
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
  import nfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  op_e         op_in,
  input  logic [7:0]  byte_in,
  input  strobe_tim_t tim_in,
  input  logic        ce_force,
  input  logic [7:0]  dq_in,
  output logic        idle,
  output logic        fin,
  output logic [7:0]  rd_byte,
  output logic        ce_n,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  dq_out,
  output logic        dq_oe
);
  phase_e      ph;
  op_e         op_q;
  logic [7:0]  byte_q, rd_q;
  strobe_tim_t tim_q;
  logic [3:0]  cnt;
  logic        active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; op_q <= OP_CMD; byte_q <= '0; rd_q <= '0; tim_q <= '0; cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          op_q <= op_in; byte_q <= byte_in; tim_q <= tim_in;
          if (tim_in.setup != 4'd0) begin ph <= PH_SETUP; cnt <= tim_in.setup - 4'd1; end
          else begin ph <= PH_PULSE; cnt <= pulse_load(tim_in.width); end
        end
        PH_SETUP: if (cnt == 4'd0) begin ph <= PH_PULSE; cnt <= pulse_load(tim_q.width); end
                  else cnt <= cnt - 4'd1;
        PH_PULSE: if (cnt == 4'd0) begin
          if (op_q == OP_RDAT) rd_q <= dq_in;
          if (tim_q.hold != 4'd0) begin ph <= PH_HOLD; cnt <= tim_q.hold - 4'd1; end
          else if (tim_q.rwait != 4'd0) begin ph <= PH_RWAIT; cnt <= tim_q.rwait - 4'd1; end
          else ph <= PH_IDLE;
        end else cnt <= cnt - 4'd1;
        PH_HOLD: if (cnt == 4'd0) begin
          if (tim_q.rwait != 4'd0) begin ph <= PH_RWAIT; cnt <= tim_q.rwait - 4'd1; end
          else ph <= PH_IDLE;
        end else cnt <= cnt - 4'd1;
        PH_RWAIT: if (cnt == 4'd0) ph <= PH_IDLE; else cnt <= cnt - 4'd1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign idle   = (ph == PH_IDLE);
  assign fin    = (cnt == 4'd0) &&
                  ((ph == PH_PULSE && tim_q.hold == 4'd0 && tim_q.rwait == 4'd0) ||
                   (ph == PH_HOLD && tim_q.rwait == 4'd0) || (ph == PH_RWAIT));
  assign rd_byte = (ph == PH_PULSE) ? dq_in : rd_q;
  assign active = (ph == PH_SETUP) || (ph == PH_PULSE) || (ph == PH_HOLD);
  assign ce_n   = ~(ce_force | active);
  assign cle    = active && (op_q == OP_CMD);
  assign ale    = active && (op_q == OP_ADDR);
  assign we_n   = ~((ph == PH_PULSE) && (op_q != OP_RDAT));
  assign re_n   = ~((ph == PH_PULSE) && (op_q == OP_RDAT));
  assign dq_out = byte_q;
  assign dq_oe  = active && (op_q != OP_RDAT);

  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !start);
  assert_strobe_in_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  assert_op_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !fin) |=> ($stable(byte_q) && $stable(op_q)));
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
#(
  parameter logic [31:0] TIM_RST = 32'h1111_1111,
  parameter int          CNT_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_wr,
  input  logic [3:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  input  logic        idle,
  input  logic        fin,
  input  logic [7:0]  rd_byte,
  input  logic        rdy_level,
  input  logic        rdy_rise,
  output logic        start,
  output op_e         op_sel,
  output logic [7:0]  op_byte,
  output strobe_tim_t tim_sel,
  output logic        ce_force,
  output logic        irq
);
  localparam int PAD_W = 32 - CNT_W;

  logic [5:1]       cfg_q;
  logic [1:0]       ien_q, iraw_q;
  logic [31:0]      tim_q;
  logic [CNT_W-1:0] cnt_q;
  op_e              cur_op;
  logic             acc, wr, rd, soft_rst, data_fin, tc_hit, cnt_wr;
  logic [1:0]       clr_mask, set_mask;
  logic [31:0]      rd_mux;

  assign req_ready = idle;
  assign acc       = req_valid & req_ready;
  assign wr        = acc & req_wr;
  assign rd        = acc & ~req_wr;
  assign soft_rst  = wr && (req_addr == RA_CTRL) && req_wdata[2];
  assign cnt_wr    = wr && (req_addr == RA_COUNT);

  always_comb begin
    case (req_addr)
      RA_ADDR: op_sel = OP_ADDR;
      RA_DATA: op_sel = req_wr ? OP_WDAT : OP_RDAT;
      default: op_sel = OP_CMD;
    endcase
  end

  assign start   = (wr && (req_addr == RA_CMD || req_addr == RA_ADDR || req_addr == RA_DATA)) ||
                   (rd && req_addr == RA_DATA);
  assign op_byte = req_wdata[7:0];
  assign tim_sel = (op_sel == OP_RDAT) ? strobe_tim_t'(tim_q[15:0]) : strobe_tim_t'(tim_q[31:16]);
  assign ce_force = cfg_q[5];
  assign irq      = |(iraw_q & ien_q);

  assign data_fin = fin && (cur_op == OP_WDAT || cur_op == OP_RDAT);
  assign tc_hit   = data_fin && (cnt_q == CNT_W'(1));
  assign clr_mask = (wr && req_addr == RA_ICLR) ? req_wdata[1:0] : 2'b00;
  assign set_mask = {tc_hit, rdy_rise};

  always_comb begin
    case (req_addr)
      RA_CFG:    rd_mux = {26'd0, cfg_q, 1'b0};
      RA_STAT:   rd_mux = {29'd0, 1'b0, 1'b0, rdy_level};
      RA_IRAW:   rd_mux = {30'd0, iraw_q};
      RA_IEN:    rd_mux = {30'd0, ien_q};
      RA_TIMING: rd_mux = tim_q;
      RA_COUNT:  rd_mux = {{PAD_W{1'b0}}, cnt_q};
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0; ien_q <= '0; iraw_q <= '0; tim_q <= TIM_RST; cnt_q <= '0;
      cur_op <= OP_CMD; rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (rd && req_addr != RA_DATA) begin rsp_valid <= 1'b1; rsp_data <= rd_mux; end
      if (fin && cur_op == OP_RDAT) begin rsp_valid <= 1'b1; rsp_data <= {24'd0, rd_byte}; end
      if (start) cur_op <= op_sel;
      if (soft_rst) begin
        cfg_q <= '0; ien_q <= '0; iraw_q <= '0; tim_q <= TIM_RST; cnt_q <= '0;
      end else begin
        if (wr && req_addr == RA_CFG)    cfg_q <= req_wdata[5:1];
        if (wr && req_addr == RA_IEN)    ien_q <= req_wdata[1:0];
        if (wr && req_addr == RA_TIMING) tim_q <= req_wdata;
        if (cnt_wr) cnt_q <= req_wdata[CNT_W-1:0];
        else if (data_fin && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
        iraw_q <= (iraw_q & ~clr_mask) | set_mask;
      end
    end
  end

  assert_count_no_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q <= $past(cnt_q)));
  assert_tc_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iraw_q[1]) |-> (cnt_q == '0));
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == RA_ICLR && req_wdata[0] && !rdy_rise) |=> !iraw_q[0]);
  assert_start_only_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nfc_pkg::*;
#(
  parameter logic [31:0] TIM_RST     = 32'h1111_1111,
  parameter int          CNT_W       = 16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req_valid,
  output logic        host_req_ready,
  input  logic        host_req_write,
  input  logic [3:0]  host_req_addr,
  input  logic [31:0] host_req_wdata,
  output logic        host_rsp_valid,
  output logic [31:0] host_rsp_data,
  output logic        irq,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rdy
);
  logic        idle, fin, start, ce_force, rdy_level, rdy_rise;
  logic [7:0]  rd_byte, op_byte;
  op_e         op_sel;
  strobe_tim_t tim_sel;

  nfc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(nand_rdy), .level(rdy_level), .rise(rdy_rise));

  nfc_regs #(.TIM_RST(TIM_RST), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(host_req_valid), .req_ready(host_req_ready),
    .req_wr(host_req_write), .req_addr(host_req_addr), .req_wdata(host_req_wdata),
    .rsp_valid(host_rsp_valid), .rsp_data(host_rsp_data), .idle(idle), .fin(fin),
    .rd_byte(rd_byte), .rdy_level(rdy_level), .rdy_rise(rdy_rise), .start(start),
    .op_sel(op_sel), .op_byte(op_byte), .tim_sel(tim_sel), .ce_force(ce_force), .irq(irq));

  nfc_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_sel), .byte_in(op_byte),
    .tim_in(tim_sel), .ce_force(ce_force), .dq_in(nand_dq_in), .idle(idle), .fin(fin),
    .rd_byte(rd_byte), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe));
endmodule

// File: tb/tb_nand_bus_ctrl.sv
`timescale 1ns/1ps
module tb_nand_bus_ctrl;
  localparam logic [31:0] TIM_RST = 32'h1111_1111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req_valid = 1'b0, host_req_write = 1'b0;
  logic [3:0] host_req_addr = '0;
  logic [31:0] host_req_wdata = '0;
  logic host_req_ready, host_rsp_valid, irq;
  logic [31:0] host_rsp_data;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_out, nand_dq_in = '0;
  logic nand_rdy = 1'b1;

  int n_chk = 0, n_fail = 0;
  int m_setup, m_pulse, m_hold, m_rwait;
  logic m_rsp, m_cle, m_ale;
  logic [31:0] m_rdata;
  logic [7:0] m_byte, rd_base = 8'h40;
  int re_run = 0;

  always #2 clk = ~clk;

  nand_bus_ctrl #(.TIM_RST(TIM_RST)) dut (.*);

  // flash model: a new byte in every read-pulse clock
  always @(negedge clk) begin
    if (!nand_re_n) begin re_run = re_run + 1; nand_dq_in = rd_base + 8'(re_run); end
    else re_run = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_op(input logic w, input logic [3:0] a, input logic [31:0] d);
    logic seen;
    m_setup = 0; m_pulse = 0; m_hold = 0; m_rwait = 0; m_rsp = 0; m_rdata = 'x;
    m_byte = 'x; m_cle = 'x; m_ale = 'x; seen = 0;
    @(negedge clk);
    host_req_valid = 1; host_req_write = w; host_req_addr = a; host_req_wdata = d;
    while (!host_req_ready) @(negedge clk);
    @(negedge clk);
    host_req_valid = 0;
    for (int i = 0; i < 200; i++) begin
      if (host_rsp_valid) begin m_rsp = 1; m_rdata = host_rsp_data; end
      if (!nand_we_n || !nand_re_n) begin
        seen = 1; m_pulse++;
        if (!nand_we_n) begin m_byte = nand_dq_out; m_cle = nand_cle; m_ale = nand_ale; end
      end else if (!nand_ce_n && !seen && !host_req_ready) m_setup++;
      else if (!nand_ce_n && seen && !host_req_ready) m_hold++;
      else if (nand_ce_n && !host_req_ready) m_rwait++;
      if (host_req_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic reg_rd(input logic [3:0] a);
    host_op(1'b0, a, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ce_n", nand_ce_n, 1); chk("R1 we_n", nand_we_n, 1); chk("R1 re_n", nand_re_n, 1);
    chk("R1 cle/ale", {nand_cle, nand_ale}, 0); chk("R1 irq", irq, 0);
    chk("R1 ready", host_req_ready, 1);
    reg_rd(4'd9);  chk("R1 timing", m_rdata, TIM_RST);
    reg_rd(4'd3);  chk("R1 cfg", m_rdata, 0);
    reg_rd(4'd6);  chk("R1 iraw", m_rdata, 0);
    reg_rd(4'd10); chk("R1 count", m_rdata, 0);
  endtask

  task automatic t_cmd_addr();
    host_op(1, 4'd9, 32'h2312_1321);
    host_op(1, 4'd0, 32'h0000_01A5);
    chk("R2 cmd byte", m_byte, 8'hA5); chk("R2 cle", m_cle, 1); chk("R2 ale", m_ale, 0);
    chk("R4 w setup", m_setup, 2); chk("R4 w pulse", m_pulse, 3); chk("R4 w hold", m_hold, 1);
    chk("R5 w rwait", m_rwait, 2);
    chk("R12 busy clocks", m_setup + m_pulse + m_hold + m_rwait, 8);
    host_op(1, 4'd1, 32'h0000_003C);
    chk("R3 addr byte", m_byte, 8'h3C); chk("R3 ale", m_ale, 1); chk("R3 cle", m_cle, 0);
  endtask

  task automatic t_read();
    rd_base = 8'h40;
    host_op(0, 4'd2, 0);
    chk("R4 r setup", m_setup, 1); chk("R4 r pulse", m_pulse, 3); chk("R4 r hold", m_hold, 2);
    chk("R5 r rwait", m_rwait, 1);
    chk("R6 rsp seen", m_rsp, 1); chk("R6 read byte", m_rdata, 32'h43);
  endtask

  task automatic t_zero();
    host_op(1, 4'd9, 32'h0000_0000);
    host_op(1, 4'd2, 32'h0000_0077);
    chk("R4 zero setup", m_setup, 0); chk("R4 zero pulse", m_pulse, 1);
    chk("R4 zero hold", m_hold, 0); chk("R6 write byte", m_byte, 8'h77);
    chk("R5 zero rwait", m_rwait, 0);
    rd_base = 8'h90;
    host_op(0, 4'd2, 0);
    chk("R6 single-clock read", m_rdata, 32'h91);
  endtask

  task automatic t_ce();
    host_op(1, 4'd3, 32'h20);
    reg_rd(4'd3); chk("R7 cfg readback", m_rdata, 32'h20);
    @(negedge clk); chk("R7 forced ce idle", nand_ce_n, 0);
    host_op(1, 4'd3, 32'h0);
    @(negedge clk); chk("R7 released ce idle", nand_ce_n, 1);
  endtask

  task automatic t_ready_irq();
    nand_rdy = 0; repeat (6) @(negedge clk);
    reg_rd(4'd4); chk("R8 status low", m_rdata, 0);
    host_op(1, 4'd8, 32'h3);
    nand_rdy = 1; repeat (6) @(negedge clk);
    reg_rd(4'd4); chk("R8 status high", m_rdata, 1);
    reg_rd(4'd6); chk("R9 rdy flag", m_rdata, 1);
    chk("R9 irq masked", irq, 0);
    host_op(1, 4'd7, 32'h1); @(negedge clk);
    chk("R9 irq enabled", irq, 1);
    host_op(1, 4'd8, 32'h1);
    reg_rd(4'd6); chk("R9 cleared", m_rdata, 0);
    chk("R9 irq gone", irq, 0);
  endtask

  task automatic t_count();
    host_op(1, 4'd10, 32'd2);
    host_op(1, 4'd0, 32'h70);
    reg_rd(4'd10); chk("R10 cmd no step", m_rdata, 2);
    host_op(1, 4'd2, 32'h11);
    reg_rd(4'd10); chk("R10 step", m_rdata, 1);
    reg_rd(4'd6);  chk("R10 no tc yet", m_rdata, 0);
    host_op(1, 4'd2, 32'h12);
    reg_rd(4'd10); chk("R10 zero", m_rdata, 0);
    reg_rd(4'd6);  chk("R10 tc set", m_rdata, 2);
    host_op(1, 4'd2, 32'h13);
    reg_rd(4'd10); chk("R10 hold at zero", m_rdata, 0);
  endtask

  task automatic t_soft_reset();
    host_op(1, 4'd9, 32'h5555_5555);
    host_op(1, 4'd3, 32'h20);
    host_op(1, 4'd10, 32'd9);
    host_op(1, 4'd5, 32'h4);
    reg_rd(4'd9);  chk("R11 timing", m_rdata, TIM_RST);
    reg_rd(4'd3);  chk("R11 cfg", m_rdata, 0);
    reg_rd(4'd7);  chk("R11 ien", m_rdata, 0);
    reg_rd(4'd6);  chk("R11 iraw", m_rdata, 0);
    reg_rd(4'd10); chk("R11 count", m_rdata, 0);
    @(negedge clk); chk("R11 ce released", nand_ce_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cmd_addr();
    t_read();
    t_zero();
    t_ce();
    t_ready_irq();
    t_count();
    t_soft_reset();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule